// File: doc/BRIEF.md
# Single-Wire Serial Number Responder

This block is the target side of a time-slotted, single-wire identification bus. It watches one open-drain data line through a sampled input. It can pull that line low through an enable output. The external pad is expected to turn `pull_o` into an open-drain driver, and a pull-up resistor holds the line high otherwise. The block carries a fixed 48-bit serial number and an 8-bit family code as parameters. From these it forms a 64-bit identity word, with a CRC byte computed at elaboration time.

The bus master opens every exchange with a long low pulse. The responder answers that pulse with a presence pulse. The master then writes an 8-bit command, one bit per write slot. If the command asks for the identity, the responder returns 64 bits, one per slot that the master starts. For a 0 bit the responder holds the line low for a while; for a 1 bit it leaves the line alone. All timing is counted in microsecond ticks, which an internal divider derives from the system clock.

Top module: `swid_responder`

## Requirements
- R1: After `rst_ni` is released, `pull_o` is 0 and the line is left high until the bus delivers a reset pulse.
- R2: When the line has been low for at least 490 µs and is then released, `pull_o` rises no sooner than 15 µs and no later than 60 µs after the release. This applies in any state.
- R3: The presence pulse keeps `pull_o` at 1 for between 60 µs and 240 µs. It is asserted at 140 µs after the release and deasserted by 170 µs.
- R4: A low of 470 µs or less is not a reset and produces no presence pulse.
- R5: In a write slot, the line level about 22 µs after the master's falling edge is taken as the bit: high is 1 and low is 0. Command bits arrive least significant first. The responder never pulls the line during the command phase.
- R6: Command 0x33 returns 64 bits, one per master-started slot, in transmit order. Bits 0–7 are the family code (0x01), least significant bit first. Bits 8–55 are the 48-bit serial number, least significant bit first.
- R7: Bits 56–63 are the CRC-8 of bits 0–55, sent least significant bit first. The CRC uses polynomial x^8+x^5+x^4+1 in reflected form, and its register starts at 0.
- R8: In a read slot, the responder pulls only after the master's falling edge. For a 0 bit the line is low at 15 µs after the edge and released by 45 µs. For a 1 bit the line is never pulled.
- R9: Any command other than 0x33 leaves the line untouched in all following slots, until the next reset pulse.
- R10: A reset pulse sent in the middle of the 64-bit transfer abandons it. The next 0x33 command restarts the transfer from bit 0.
- R11: Once all 64 bits have been sent, further read slots return 1 until the next reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Sampled level of the data line (1 = high) |
| pull_o | output | 1 | 1 = pull the data line low |

## Verification
A corrupted bit index or a wrong state shows up within one slot (about 75 µs). It appears at the line as a wrong bit in the 64-bit identity word, or as a pull where the responder should stay silent. A command register that shifts in the wrong order is visible as soon as the 8th write slot ends. The responder then goes silent for 0x33, or answers a near-miss code such as 0x32 or 0xB3. An error in reset-pulse detection appears at most 60 µs after release, as a missing presence pulse or one that should not be there. The bench checks this with both long and short lows.

// File: rtl/swid_pkg.sv
package swid_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PGAP  = 3'd1,
        ST_PDRV  = 3'd2,
        ST_RXCMD = 3'd3,
        ST_TXID  = 3'd4
    } swid_state_e;

    localparam int          ID_BITS    = 64;
    localparam int          BODY_BITS  = 56;
    localparam int          CMD_BITS   = 8;
    localparam logic [7:0]  CMD_SEND_ID = 8'h33;

    // Reflected CRC-8, x^8+x^5+x^4+1, fed one bit at a time in send order
    function automatic logic [7:0] swid_crc8(input logic [BODY_BITS-1:0] body);
        logic [7:0] acc;
        logic       mix;
        acc = 8'h00;
        for (int i = 0; i < BODY_BITS; i++) begin
            mix = acc[0] ^ body[i];
            acc = acc >> 1;
            if (mix) acc = acc ^ 8'h8C;
        end
        return acc;
    endfunction

endpackage

// File: rtl/swid_tick_div.sv
module swid_tick_div #(
    parameter int CLKS_PER_US = 125
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    generate
        if (CLKS_PER_US <= 1) begin : g_pass
            assign tick_o = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(CLKS_PER_US);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                if (cnt_q == CW'(CLKS_PER_US - 1)) cnt_d = '0;
                else                               cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk_i) begin
                if (!rst_ni) cnt_q <= '0;
                else         cnt_q <= cnt_d;
            end

            assign tick_o = (cnt_q == CW'(CLKS_PER_US - 1));
        end
    endgenerate
endmodule

// File: rtl/swid_line_mon.sv
module swid_line_mon #(
    parameter int RST_US = 480
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic line_i,
    output logic line_o,
    output logic fall_o,
    output logic rst_det_o
);
    localparam int LW = $clog2(RST_US + 1) + 1;

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          s3;
        logic [LW-1:0] low;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d    = mon_q;
        mon_d.s1 = line_i;
        mon_d.s2 = mon_q.s1;
        mon_d.s3 = mon_q.s2;
        if (mon_q.s2)                            mon_d.low = '0;
        else if (tick_i && (mon_q.low != '1))    mon_d.low = mon_q.low + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mon_q.s1  <= 1'b1;
            mon_q.s2  <= 1'b1;
            mon_q.s3  <= 1'b1;
            mon_q.low <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign line_o    = mon_q.s2;
    assign fall_o    = mon_q.s3 & ~mon_q.s2;
    assign rst_det_o = ~mon_q.s3 & mon_q.s2 & (mon_q.low >= LW'(RST_US));
endmodule

// File: rtl/swid_slot_seq.sv
module swid_slot_seq
    import swid_pkg::*;
#(
    parameter logic [ID_BITS-1:0] ID_WORD    = '0,
    parameter int                 PD_WAIT_US = 30,
    parameter int                 PD_LEN_US  = 120,
    parameter int                 SAMPLE_US  = 22,
    parameter int                 HOLD_US    = 30
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          tick_i,
    input  logic                          line_i,
    input  logic                          fall_i,
    input  logic                          rst_det_i,
    output logic                          pull_o,
    output swid_state_e                   state_o,
    output logic [$clog2(ID_BITS):0]      bitn_o
);
    localparam int TW = $clog2(PD_WAIT_US + PD_LEN_US + SAMPLE_US + HOLD_US + 1);
    localparam int IW = $clog2(ID_BITS);
    localparam int BW = IW + 1;

    typedef struct packed {
        swid_state_e         st;
        logic [TW-1:0]       tcnt;
        logic [BW-1:0]       bitn;
        logic [CMD_BITS-1:0] cmd;
        logic                slot;
        logic                pull;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [CMD_BITS-1:0] cmd_next;

    assign cmd_next = {line_i, seq_q.cmd[CMD_BITS-1:1]};

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
            end
            ST_PGAP: begin
                if (tick_i) begin
                    if (seq_q.tcnt == TW'(PD_WAIT_US - 1)) begin
                        seq_d.st   = ST_PDRV;
                        seq_d.tcnt = '0;
                        seq_d.pull = 1'b1;
                    end else begin
                        seq_d.tcnt = seq_q.tcnt + 1'b1;
                    end
                end
            end
            ST_PDRV: begin
                if (tick_i) begin
                    if (seq_q.tcnt == TW'(PD_LEN_US - 1)) begin
                        seq_d.st   = ST_RXCMD;
                        seq_d.tcnt = '0;
                        seq_d.pull = 1'b0;
                        seq_d.bitn = '0;
                        seq_d.slot = 1'b0;
                    end else begin
                        seq_d.tcnt = seq_q.tcnt + 1'b1;
                    end
                end
            end
            ST_RXCMD: begin
                if (!seq_q.slot) begin
                    if (fall_i) begin
                        seq_d.slot = 1'b1;
                        seq_d.tcnt = '0;
                    end
                end else if (tick_i) begin
                    if (seq_q.tcnt == TW'(SAMPLE_US - 1)) begin
                        seq_d.slot = 1'b0;
                        seq_d.cmd  = cmd_next;
                        if (seq_q.bitn == BW'(CMD_BITS - 1)) begin
                            seq_d.bitn = '0;
                            seq_d.st   = (cmd_next == CMD_SEND_ID) ? ST_TXID : ST_IDLE;
                        end else begin
                            seq_d.bitn = seq_q.bitn + 1'b1;
                        end
                    end else begin
                        seq_d.tcnt = seq_q.tcnt + 1'b1;
                    end
                end
            end
            ST_TXID: begin
                if (!seq_q.slot) begin
                    if (fall_i) begin
                        seq_d.slot = 1'b1;
                        seq_d.tcnt = '0;
                        seq_d.pull = ~ID_WORD[seq_q.bitn[IW-1:0]];
                    end
                end else if (tick_i) begin
                    if (seq_q.tcnt == TW'(HOLD_US - 1)) begin
                        seq_d.slot = 1'b0;
                        seq_d.pull = 1'b0;
                        if (seq_q.bitn == BW'(ID_BITS - 1)) begin
                            seq_d.st   = ST_IDLE;
                            seq_d.bitn = '0;
                        end else begin
                            seq_d.bitn = seq_q.bitn + 1'b1;
                        end
                    end else begin
                        seq_d.tcnt = seq_q.tcnt + 1'b1;
                    end
                end
            end
            default: begin
                seq_d.st   = ST_IDLE;
                seq_d.pull = 1'b0;
            end
        endcase

        // a long low overrides whatever was in progress
        if (rst_det_i) begin
            seq_d.st   = ST_PGAP;
            seq_d.tcnt = '0;
            seq_d.bitn = '0;
            seq_d.slot = 1'b0;
            seq_d.pull = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q.st   <= ST_IDLE;
            seq_q.tcnt <= '0;
            seq_q.bitn <= '0;
            seq_q.cmd  <= '0;
            seq_q.slot <= 1'b0;
            seq_q.pull <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pull_o  = seq_q.pull;
    assign state_o = seq_q.st;
    assign bitn_o  = seq_q.bitn;
endmodule

// File: rtl/swid_responder.sv
module swid_responder
    import swid_pkg::*;
#(
    parameter logic [47:0] SERIAL      = 48'h0000_0000_0001,
    parameter logic [7:0]  FAMILY      = 8'h01,
    parameter int          CLKS_PER_US = 125,
    parameter int          RST_US      = 480,
    parameter int          PD_WAIT_US  = 30,
    parameter int          PD_LEN_US   = 120,
    parameter int          SAMPLE_US   = 22,
    parameter int          HOLD_US     = 30
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic pull_o
);
    localparam logic [BODY_BITS-1:0] ID_BODY = {SERIAL, FAMILY};
    localparam logic [ID_BITS-1:0]   ID_WORD = {swid_crc8(ID_BODY), ID_BODY};
    localparam int                   BW      = $clog2(ID_BITS) + 1;

    logic             tick;
    logic             line_s;
    logic             fall;
    logic             rst_det;
    swid_state_e      seq_st;
    logic [BW-1:0]    seq_bitn;

    swid_tick_div #(
        .CLKS_PER_US(CLKS_PER_US)
    ) i_tick_div (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_o(tick)
    );

    swid_line_mon #(
        .RST_US(RST_US)
    ) i_line_mon (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .line_i   (line_i),
        .line_o   (line_s),
        .fall_o   (fall),
        .rst_det_o(rst_det)
    );

    swid_slot_seq #(
        .ID_WORD   (ID_WORD),
        .PD_WAIT_US(PD_WAIT_US),
        .PD_LEN_US (PD_LEN_US),
        .SAMPLE_US (SAMPLE_US),
        .HOLD_US   (HOLD_US)
    ) i_slot_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .line_i   (line_s),
        .fall_i   (fall),
        .rst_det_i(rst_det),
        .pull_o   (pull_o),
        .state_o  (seq_st),
        .bitn_o   (seq_bitn)
    );
endmodule

// File: rtl/swid_checker.sv
module swid_checker
    import swid_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        line_s,
    input logic        pull,
    input logic        rst_det,
    input swid_state_e st,
    input logic [6:0]  bitn
);
    logic [8:0] pull_ticks;

    always_ff @(posedge clk) begin
        if (!rst_n)                          pull_ticks <= '0;
        else if (!pull)                      pull_ticks <= '0;
        else if (tick && pull_ticks != '1)   pull_ticks <= pull_ticks + 1'b1;
    end

    AST_PULL_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        pull_ticks <= 9'd240);                                          // R3

    AST_RESET_TO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_det |=> (st == ST_PGAP) && !pull);                          // R2

    AST_CMD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RXCMD) |-> !pull);                                    // R5

    AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pull) && st == ST_TXID) |-> !$past(line_s));             // R8

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !pull);                                     // R9

    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bitn < 7'd64);                                                  // R11
endmodule

bind swid_responder swid_checker i_swid_checker (
    .clk    (clk_i),
    .rst_n  (rst_ni),
    .tick   (tick),
    .line_s (line_s),
    .pull   (pull_o),
    .rst_det(rst_det),
    .st     (seq_st),
    .bitn   (seq_bitn)
);

// File: tb/test_swid_responder.sv
module test_swid_responder;
    localparam int          CPU = 2;
    localparam logic [47:0] SER = 48'h3A5C_91E7_042B;
    localparam logic [7:0]  FAM = 8'h01;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_pull = 1'b0;
    logic pull;
    wire  line = ~(m_pull | pull);

    always #4 clk = ~clk;

    swid_responder #(
        .SERIAL     (SER),
        .FAMILY     (FAM),
        .CLKS_PER_US(CPU)
    ) i_swid_responder (
        .clk_i (clk),
        .rst_ni(rst_n),
        .line_i(line),
        .pull_o(pull)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (n * CPU) @(negedge clk);
    endtask

    // CRC in the non-reflected MSB-first form with poly 0x31, then mirrored
    function automatic logic [63:0] exp_word();
        logic [55:0] body;
        logic [7:0]  n;
        logic [7:0]  r;
        logic        fb;
        body = {SER, FAM};
        n = 8'h00;
        for (int i = 0; i < 56; i++) begin
            fb = n[7] ^ body[i];
            n  = {n[6:0], 1'b0};
            if (fb) n = n ^ 8'h31;
        end
        for (int j = 0; j < 8; j++) r[j] = n[7 - j];
        return {r, body};
    endfunction

    task automatic bus_reset(input int low_us, input logic pres);
        m_pull = 1'b1;
        wait_us(low_us);
        m_pull = 1'b0;
        wait_us(10);
        chk(pres ? "R2 no pull 10us after release" : "R4 no pull at 10us", pull, 1'b0);
        wait_us(35);
        chk(pres ? "R2 presence at 45us" : "R4 no presence at 45us", pull, pres);
        wait_us(95);
        chk(pres ? "R3 presence at 140us" : "R4 no presence at 140us", pull, pres);
        wait_us(30);
        chk(pres ? "R3 presence over by 170us" : "R4 quiet at 170us", pull, 1'b0);
        wait_us(70);
    endtask

    task automatic write_bit(input logic b);
        m_pull = 1'b1;
        wait_us(b ? 5 : 70);
        chk("R5 responder silent in write slot", pull, 1'b0);
        m_pull = 1'b0;
        wait_us(b ? 75 : 10);
    endtask

    task automatic write_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) write_bit(v[i]);
    endtask

    task automatic read_bit(output logic v);
        chk("R8 no drive before master edge", pull, 1'b0);
        m_pull = 1'b1;
        wait_us(2);
        m_pull = 1'b0;
        wait_us(13);
        v = line;
        wait_us(30);
        chk("R8 line released by 45us", line, 1'b1);
        wait_us(30);
    endtask

    task automatic read_id(input int count, input string tag);
        logic [63:0] w;
        logic        v;
        w = exp_word();
        for (int i = 0; i < count; i++) begin
            read_bit(v);
            chk($sformatf("%s bit %0d", (i < 56) ? tag : "R7 crc", i), v, w[i]);
        end
    endtask

    task automatic read_ones(input int count, input string tag);
        logic v;
        for (int i = 0; i < count; i++) begin
            read_bit(v);
            chk($sformatf("%s slot %0d", tag, i), v, 1'b1);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] bad_cmds [5];
        int         k;
        void'($urandom(32'd1207));

        repeat (5) @(negedge clk);
        chk("R1 pull low during reset", pull, 1'b0);
        rst_n = 1'b1;
        wait_us(20);
        chk("R1 pull idle after reset", pull, 1'b0);
        chk("R1 line high after reset", line, 1'b1);

        // full identity read, then trailing slots
        bus_reset(500, 1'b1);
        write_byte(8'h33);
        read_id(64, "R6 id");
        read_ones(4, "R11 after last bit");

        // short low is not a reset
        bus_reset(300, 1'b0);

        // near misses on bit order, then random other codes
        bad_cmds[0] = 8'h32;
        bad_cmds[1] = 8'hB3;
        bad_cmds[2] = 8'hCC;
        for (int i = 3; i < 5; i++) begin
            bad_cmds[i] = 8'($urandom);
            if (bad_cmds[i] == 8'h33) bad_cmds[i] = 8'h31;
        end
        for (int i = 0; i < 5; i++) begin
            bus_reset(500, 1'b1);
            write_byte(bad_cmds[i]);
            read_ones(6, $sformatf("R9 cmd %02h", bad_cmds[i]));
        end

        // abort in the middle and restart
        bus_reset(500, 1'b1);
        write_byte(8'h33);
        k = $urandom_range(30, 4);
        read_id(k, "R10 before abort");
        bus_reset(520, 1'b1);
        write_byte(8'h33);
        read_id(64, "R10 restart");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule